// File: doc/BRIEF.md
# Shadow Stack Return-Address Unit

This execute-stage unit guards the backward edge of control flow on a core that runs either 32-bit or 64-bit code. It owns the shadow stack pointer and carries out five operations on it: saving a link register to the shadow stack, restoring a link register from it, copying the pointer into a general register, comparing the two link registers, and an atomic exchange of one shadow stack word. The core hands it one decoded operation at a time with register indices and operand values already read. The unit returns a single writeback (or a fault) when the operation has finished.

Memory traffic goes out on a single-outstanding request port: one request, held until accepted, then one response that carries load data or an error. The pointer only moves once a response has come back clean, so a fault never leaves the stack half-updated. When protection is switched off, or an operand register is outside what an operation allows, the operation degrades to a harmless "write zero to rd". On a core without that fallback it becomes an illegal-instruction fault.

Top module: `shadow_stack_unit`

## Requirements
- R1: Operation code 0 (save) with width W bytes (W = 8 when `wide_mode` is 1, else 4) issues one store (`mem_req_kind` = 1) of `rs1_val` (low 32 bits in narrow mode) at pointer minus W, writes no register, and after a clean response the pointer equals the old pointer minus W.
- R2: Operation code 1 (restore) issues one load (`mem_req_kind` = 0) at the current pointer. After a clean response it writes the returned word to `rd_idx` (low 32 bits zero-extended in narrow mode) and raises the pointer by W; saves and restores behave last-in first-out.
- R3: Save accepts only source index 1 or 5 and restore only destination index 1 or 5. Any other index makes the operation write zero to `rd_idx` without a memory request and without moving the pointer.
- R4: With `ss_enable` low, every operation code writes zero to `rd_idx`, issues no memory request and leaves the pointer unchanged; code 2 then returns zero rather than the pointer.
- R5: When an operation falls back and `mop_support` is low, the unit reports `fault_illegal` and writes no register.
- R6: Operation code 3 (link check) compares `rs1_val` (x1) with `rs2_val` (x5): equal values complete with no fault and no write, different values raise `fault_illegal` with no write.
- R7: Operation code 2 (pointer read) writes the current pointer to `rd_idx`.
- R8: Operation code 4 (exchange) issues `mem_req_kind` = 2 at address `rs1_val` with data `rs2_val`, and writes the old word to `rd_idx` (sign-extended from bit 31 in narrow mode). With `rd_idx` = 0 it falls back as in R3.
- R9: An access address not aligned to W raises `fault_misalign`, issues no memory request, writes no register and leaves the pointer unchanged.
- R10: A response with `mem_rsp_err` set raises `fault_access`, writes no register and leaves the pointer unchanged; the pointer changes only in the cycle a successful writeback is reported.
- R11: `op_ready` is high only while no operation is in flight; each accepted operation yields exactly one one-cycle `wb_valid`, which comes in the cycle after acceptance for operations without memory access; a pending memory request holds its address until accepted.
- R12: After reset the unit is ready, shows no request or writeback, and the pointer holds its reset value (0x100 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | An operation is offered |
| op_ready | output | 1 | Unit can accept an operation |
| op_code | input | 3 | 0 save, 1 restore, 2 pointer read, 3 link check, 4 exchange, 5-7 fallback |
| rd_idx | input | IDX_W | Destination register index |
| rs1_idx | input | IDX_W | First source register index |
| rs1_val | input | XLEN | First source value (x1 for link check, address for exchange) |
| rs2_val | input | XLEN | Second source value (x5 for link check, data for exchange) |
| ss_enable | input | 1 | Backward-edge protection active |
| mop_support | input | 1 | Fallback "write zero" behaviour available |
| wide_mode | input | 1 | 1 = 64-bit operation, 0 = 32-bit |
| mem_req_valid | output | 1 | Memory request pending |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_kind | output | 2 | 0 load, 1 store, 2 exchange |
| mem_req_wide | output | 1 | Access width is 8 bytes |
| mem_req_addr | output | XLEN | Access address |
| mem_req_wdata | output | XLEN | Store or exchange data |
| mem_rsp_valid | input | 1 | Response arrives |
| mem_rsp_err | input | 1 | Response reports an access error |
| mem_rsp_data | input | XLEN | Load or old exchange word |
| wb_valid | output | 1 | Operation finished (one cycle) |
| wb_we | output | 1 | Register write requested |
| wb_rd | output | IDX_W | Register written |
| wb_data | output | XLEN | Value written |
| fault_illegal | output | 1 | Illegal-instruction fault |
| fault_misalign | output | 1 | Misaligned shadow stack access |
| fault_access | output | 1 | Memory returned an error |

## Verification
A corrupted pointer is invisible until an access or a pointer read uses it. The bench therefore reads the pointer back right after every save, restore, fault and fallback, so a wrong value shows at the writeback port within one operation. A pairing of saves and restores in reverse order exposes a wrong offset or width through the data popped. A stuck or mis-sequenced controller shows as a missing, doubled or stretched `wb_valid`, or as `op_ready` rising while a request is still outstanding.

// File: rtl/ssu_pkg.sv
// Shared encodings of the shadow stack unit.
// Assumes: operation codes and memory kinds are fixed by the core's decoder.
package ssu_pkg;

    typedef enum logic [2:0] {
        SS_SAVE    = 3'd0,
        SS_RESTORE = 3'd1,
        SS_RDPTR   = 3'd2,
        SS_CHECK   = 3'd3,
        SS_XCHG    = 3'd4
    } ss_op_e;

    typedef enum logic [1:0] {
        MEM_LOAD  = 2'd0,
        MEM_STORE = 2'd1,
        MEM_XCHG  = 2'd2
    } mem_kind_e;

    typedef enum logic [1:0] {
        ACT_FALLBACK,
        ACT_MEM,
        ACT_RDPTR,
        ACT_CHECK
    } ss_act_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT,
        ST_DONE
    } ss_state_e;

endpackage

// File: rtl/ssu_classify.sv
// Combinational classification of an offered operation: decides whether it
// is legal, which action it takes, the memory address/data and the pointer
// value to commit on success.
// Assumes: XLEN >= 64; in narrow mode only the low 32 bits of data matter.
module ssu_classify
    import ssu_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int IDX_W = 5
) (
    input  logic [2:0]       op_code,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [IDX_W-1:0] rs1_idx,
    input  logic [XLEN-1:0]  rs1_val,
    input  logic [XLEN-1:0]  rs2_val,
    input  logic             ss_enable,
    input  logic             wide_mode,
    input  logic [XLEN-1:0]  ssp,
    output ss_act_e          act,
    output mem_kind_e        kind,
    output logic [XLEN-1:0]  addr,
    output logic [XLEN-1:0]  wdata,
    output logic [XLEN-1:0]  ptr_next,
    output logic             upd_ptr,
    output logic             aligned,
    output logic             links_equal
);
    localparam int UPPER = XLEN - 32;
    localparam logic [IDX_W-1:0] LINK_A = IDX_W'(1);
    localparam logic [IDX_W-1:0] LINK_B = IDX_W'(5);

    logic [XLEN-1:0] step;
    logic            src_is_link;
    logic            dst_is_link;

    // Width step and register-legality helpers.
    always_comb begin
        step        = wide_mode ? XLEN'(8) : XLEN'(4);
        src_is_link = (rs1_idx == LINK_A) || (rs1_idx == LINK_B);
        dst_is_link = (rd_idx == LINK_A) || (rd_idx == LINK_B);
    end

    // Per-operation action, address and pointer follow-up.
    always_comb begin
        act      = ACT_FALLBACK;
        kind     = MEM_LOAD;
        addr     = ssp;
        wdata    = '0;
        ptr_next = ssp;
        upd_ptr  = 1'b0;
        unique case (ss_op_e'(op_code))
            SS_SAVE: begin
                if (ss_enable && src_is_link) begin
                    act      = ACT_MEM;
                    kind     = MEM_STORE;
                    addr     = ssp - step;
                    wdata    = wide_mode ? rs1_val : {{UPPER{1'b0}}, rs1_val[31:0]};
                    ptr_next = ssp - step;
                    upd_ptr  = 1'b1;
                end
            end
            SS_RESTORE: begin
                if (ss_enable && dst_is_link) begin
                    act      = ACT_MEM;
                    kind     = MEM_LOAD;
                    addr     = ssp;
                    ptr_next = ssp + step;
                    upd_ptr  = 1'b1;
                end
            end
            SS_RDPTR: begin
                if (ss_enable) act = ACT_RDPTR;
            end
            SS_CHECK: begin
                if (ss_enable) act = ACT_CHECK;
            end
            SS_XCHG: begin
                if (ss_enable && (rd_idx != '0)) begin
                    act   = ACT_MEM;
                    kind  = MEM_XCHG;
                    addr  = rs1_val;
                    wdata = wide_mode ? rs2_val : {{UPPER{1'b0}}, rs2_val[31:0]};
                end
            end
            default: act = ACT_FALLBACK;
        endcase
    end

    // Natural alignment and link comparison at the active width.
    always_comb begin
        aligned     = wide_mode ? (addr[2:0] == 3'b000) : (addr[1:0] == 2'b00);
        links_equal = wide_mode ? (rs1_val == rs2_val) : (rs1_val[31:0] == rs2_val[31:0]);
    end

endmodule

// File: rtl/ssu_ptr_reg.sv
// Shadow stack pointer register.
// Assumes: the sequencer raises upd_en only for a clean memory response.
module ssu_ptr_reg #(
    parameter int              XLEN      = 64,
    parameter logic [XLEN-1:0] RESET_PTR = 'h100
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            upd_en,
    input  logic [XLEN-1:0] upd_val,
    output logic [XLEN-1:0] ptr
);
    // Hold the pointer; load the committed value on request.
    always_ff @(posedge clk) begin
        if (!rst_n)      ptr <= RESET_PTR;
        else if (upd_en) ptr <= upd_val;
    end
endmodule

// File: rtl/ssu_seq.sv
// Operation sequencer: accepts one operation, runs at most one memory
// transaction, commits the pointer on a clean response and reports the
// result with a one-cycle writeback pulse.
// Assumes: memory returns exactly one response per accepted request.
module ssu_seq
    import ssu_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    output logic             op_ready,
    input  ss_act_e          act,
    input  mem_kind_e        kind,
    input  logic [XLEN-1:0]  addr,
    input  logic [XLEN-1:0]  wdata,
    input  logic [XLEN-1:0]  ptr_next,
    input  logic             upd_ptr,
    input  logic             aligned,
    input  logic             links_equal,
    input  logic [XLEN-1:0]  ssp,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic             mop_support,
    input  logic             wide_mode,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [1:0]       mem_req_kind,
    output logic             mem_req_wide,
    output logic [XLEN-1:0]  mem_req_addr,
    output logic [XLEN-1:0]  mem_req_wdata,
    input  logic             mem_rsp_valid,
    input  logic             mem_rsp_err,
    input  logic [XLEN-1:0]  mem_rsp_data,
    output logic             wb_valid,
    output logic             wb_we,
    output logic [IDX_W-1:0] wb_rd,
    output logic [XLEN-1:0]  wb_data,
    output logic             fault_illegal,
    output logic             fault_misalign,
    output logic             fault_access,
    output logic             ptr_upd_en,
    output logic [XLEN-1:0]  ptr_upd_val
);
    localparam int UPPER = XLEN - 32;

    ss_state_e        state_q;
    mem_kind_e        kind_q;
    logic [XLEN-1:0]  addr_q;
    logic [XLEN-1:0]  wdata_q;
    logic [XLEN-1:0]  ptrn_q;
    logic             updp_q;
    logic             wide_q;
    logic [IDX_W-1:0] rd_q;
    logic             we_q;
    logic [XLEN-1:0]  data_q;
    logic             fill_q;
    logic             fmis_q;
    logic             facc_q;
    logic             accept;
    logic             rsp_ok;
    logic [XLEN-1:0]  rsp_ext;

    // Handshake and clean-response detection.
    always_comb begin
        op_ready = (state_q == ST_IDLE);
        accept   = op_valid && op_ready;
        rsp_ok   = (state_q == ST_WAIT) && mem_rsp_valid && !mem_rsp_err;
    end

    // Width adjustment of returned data: loads zero-extend, exchanges sign-extend.
    always_comb begin
        if (wide_q)                rsp_ext = mem_rsp_data;
        else if (kind_q == MEM_XCHG) rsp_ext = {{UPPER{mem_rsp_data[31]}}, mem_rsp_data[31:0]};
        else                       rsp_ext = {{UPPER{1'b0}}, mem_rsp_data[31:0]};
    end

    // State machine and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            kind_q  <= MEM_LOAD;
            addr_q  <= '0;
            wdata_q <= '0;
            ptrn_q  <= '0;
            updp_q  <= 1'b0;
            wide_q  <= 1'b0;
            rd_q    <= '0;
            we_q    <= 1'b0;
            data_q  <= '0;
            fill_q  <= 1'b0;
            fmis_q  <= 1'b0;
            facc_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        kind_q  <= kind;
                        addr_q  <= addr;
                        wdata_q <= wdata;
                        ptrn_q  <= ptr_next;
                        updp_q  <= upd_ptr;
                        wide_q  <= wide_mode;
                        rd_q    <= rd_idx;
                        we_q    <= 1'b0;
                        data_q  <= '0;
                        fill_q  <= 1'b0;
                        fmis_q  <= 1'b0;
                        facc_q  <= 1'b0;
                        state_q <= ST_DONE;
                        unique case (act)
                            ACT_FALLBACK: begin
                                we_q   <= mop_support;
                                fill_q <= !mop_support;
                            end
                            ACT_RDPTR: begin
                                we_q   <= 1'b1;
                                data_q <= ssp;
                            end
                            ACT_CHECK: fill_q <= !links_equal;
                            ACT_MEM: begin
                                if (aligned) state_q <= ST_REQ;
                                else         fmis_q  <= 1'b1;
                            end
                            default: fill_q <= 1'b1;
                        endcase
                    end
                end
                ST_REQ: begin
                    if (mem_req_ready) state_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        state_q <= ST_DONE;
                        if (mem_rsp_err) begin
                            facc_q <= 1'b1;
                        end else if (kind_q != MEM_STORE) begin
                            we_q   <= 1'b1;
                            data_q <= rsp_ext;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Port drive from registered state.
    always_comb begin
        mem_req_valid  = (state_q == ST_REQ);
        mem_req_kind   = kind_q;
        mem_req_wide   = wide_q;
        mem_req_addr   = addr_q;
        mem_req_wdata  = wdata_q;
        wb_valid       = (state_q == ST_DONE);
        wb_we          = wb_valid && we_q;
        wb_rd          = rd_q;
        wb_data        = data_q;
        fault_illegal  = wb_valid && fill_q;
        fault_misalign = wb_valid && fmis_q;
        fault_access   = wb_valid && facc_q;
        ptr_upd_en     = rsp_ok && updp_q;
        ptr_upd_val    = ptrn_q;
    end

endmodule

// File: rtl/shadow_stack_unit.sv
// Top of the shadow stack unit: classifier, pointer register and sequencer.
// Assumes: one operation in flight; operands are read before the offer.
module shadow_stack_unit
    import ssu_pkg::*;
#(
    parameter int              XLEN      = 64,
    parameter int              IDX_W     = 5,
    parameter logic [XLEN-1:0] RESET_PTR = 'h100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    output logic             op_ready,
    input  logic [2:0]       op_code,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [IDX_W-1:0] rs1_idx,
    input  logic [XLEN-1:0]  rs1_val,
    input  logic [XLEN-1:0]  rs2_val,
    input  logic             ss_enable,
    input  logic             mop_support,
    input  logic             wide_mode,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [1:0]       mem_req_kind,
    output logic             mem_req_wide,
    output logic [XLEN-1:0]  mem_req_addr,
    output logic [XLEN-1:0]  mem_req_wdata,
    input  logic             mem_rsp_valid,
    input  logic             mem_rsp_err,
    input  logic [XLEN-1:0]  mem_rsp_data,
    output logic             wb_valid,
    output logic             wb_we,
    output logic [IDX_W-1:0] wb_rd,
    output logic [XLEN-1:0]  wb_data,
    output logic             fault_illegal,
    output logic             fault_misalign,
    output logic             fault_access
);
    ss_act_e         c_act;
    mem_kind_e       c_kind;
    logic [XLEN-1:0] c_addr;
    logic [XLEN-1:0] c_wdata;
    logic [XLEN-1:0] c_ptr_next;
    logic            c_upd_ptr;
    logic            c_aligned;
    logic            c_links_equal;
    logic [XLEN-1:0] ssp_q;
    logic            ptr_upd_en;
    logic [XLEN-1:0] ptr_upd_val;

    ssu_classify #(.XLEN(XLEN), .IDX_W(IDX_W)) i_classify (
        .op_code     (op_code),
        .rd_idx      (rd_idx),
        .rs1_idx     (rs1_idx),
        .rs1_val     (rs1_val),
        .rs2_val     (rs2_val),
        .ss_enable   (ss_enable),
        .wide_mode   (wide_mode),
        .ssp         (ssp_q),
        .act         (c_act),
        .kind        (c_kind),
        .addr        (c_addr),
        .wdata       (c_wdata),
        .ptr_next    (c_ptr_next),
        .upd_ptr     (c_upd_ptr),
        .aligned     (c_aligned),
        .links_equal (c_links_equal)
    );

    ssu_ptr_reg #(.XLEN(XLEN), .RESET_PTR(RESET_PTR)) i_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd_en  (ptr_upd_en),
        .upd_val (ptr_upd_val),
        .ptr     (ssp_q)
    );

    ssu_seq #(.XLEN(XLEN), .IDX_W(IDX_W)) i_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .op_valid       (op_valid),
        .op_ready       (op_ready),
        .act            (c_act),
        .kind           (c_kind),
        .addr           (c_addr),
        .wdata          (c_wdata),
        .ptr_next       (c_ptr_next),
        .upd_ptr        (c_upd_ptr),
        .aligned        (c_aligned),
        .links_equal    (c_links_equal),
        .ssp            (ssp_q),
        .rd_idx         (rd_idx),
        .mop_support    (mop_support),
        .wide_mode      (wide_mode),
        .mem_req_valid  (mem_req_valid),
        .mem_req_ready  (mem_req_ready),
        .mem_req_kind   (mem_req_kind),
        .mem_req_wide   (mem_req_wide),
        .mem_req_addr   (mem_req_addr),
        .mem_req_wdata  (mem_req_wdata),
        .mem_rsp_valid  (mem_rsp_valid),
        .mem_rsp_err    (mem_rsp_err),
        .mem_rsp_data   (mem_rsp_data),
        .wb_valid       (wb_valid),
        .wb_we          (wb_we),
        .wb_rd          (wb_rd),
        .wb_data        (wb_data),
        .fault_illegal  (fault_illegal),
        .fault_misalign (fault_misalign),
        .fault_access   (fault_access),
        .ptr_upd_en     (ptr_upd_en),
        .ptr_upd_val    (ptr_upd_val)
    );

endmodule

// File: rtl/ssu_checker.sv
// Protocol and state properties of the shadow stack unit, bound to its top.
// Assumes: synchronous active-low reset.
module ssu_checker #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            op_valid,
    input logic            op_ready,
    input logic            ss_enable,
    input logic            mem_req_valid,
    input logic            mem_req_ready,
    input logic            mem_req_wide,
    input logic [XLEN-1:0] mem_req_addr,
    input logic            wb_valid,
    input logic            wb_we,
    input logic            fault_illegal,
    input logic            fault_misalign,
    input logic            fault_access,
    input logic [XLEN-1:0] ssp
);
    assert_wb_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |=> !wb_valid);

    assert_busy_not_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !op_ready);

    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    assert_aligned_request_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_wide ? (mem_req_addr[2:0] == 3'b000)
                                        : (mem_req_addr[1:0] == 2'b00)));

    assert_disabled_no_memory_R4: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_ready && !ss_enable |=> !mem_req_valid);

    assert_fault_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid && (fault_illegal || fault_misalign || fault_access) |-> !wb_we);

    assert_single_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({fault_illegal, fault_misalign, fault_access}) <= 1);

    assert_ptr_moves_on_success_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ssp) |-> wb_valid && !fault_access && !fault_misalign);
endmodule

bind shadow_stack_unit ssu_checker #(.XLEN(XLEN)) i_ssu_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .op_valid       (op_valid),
    .op_ready       (op_ready),
    .ss_enable      (ss_enable),
    .mem_req_valid  (mem_req_valid),
    .mem_req_ready  (mem_req_ready),
    .mem_req_wide   (mem_req_wide),
    .mem_req_addr   (mem_req_addr),
    .wb_valid       (wb_valid),
    .wb_we          (wb_we),
    .fault_illegal  (fault_illegal),
    .fault_misalign (fault_misalign),
    .fault_access   (fault_access),
    .ssp            (ssp_q)
);

// File: tb/test_shadow_stack_unit.sv
// Directed bench for the shadow stack unit with a small memory model.
module test_shadow_stack_unit;
    localparam int XLEN = 64;
    localparam int IDX_W = 5;
    localparam logic [2:0] OP_SAVE = 3'd0, OP_RESTORE = 3'd1, OP_RDPTR = 3'd2,
                           OP_CHECK = 3'd3, OP_XCHG = 3'd4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             op_valid = 1'b0;
    logic             op_ready;
    logic [2:0]       op_code = '0;
    logic [IDX_W-1:0] rd_idx = '0;
    logic [IDX_W-1:0] rs1_idx = '0;
    logic [XLEN-1:0]  rs1_val = '0;
    logic [XLEN-1:0]  rs2_val = '0;
    logic             ss_enable = 1'b1;
    logic             mop_support = 1'b1;
    logic             wide_mode = 1'b1;
    logic             mem_req_valid;
    logic             mem_req_ready;
    logic [1:0]       mem_req_kind;
    logic             mem_req_wide;
    logic [XLEN-1:0]  mem_req_addr;
    logic [XLEN-1:0]  mem_req_wdata;
    logic             mem_rsp_valid = 1'b0;
    logic             mem_rsp_err = 1'b0;
    logic [XLEN-1:0]  mem_rsp_data = '0;
    logic             wb_valid;
    logic             wb_we;
    logic [IDX_W-1:0] wb_rd;
    logic [XLEN-1:0]  wb_data;
    logic             fault_illegal;
    logic             fault_misalign;
    logic             fault_access;

    int checks = 0;
    int fails = 0;

    always #4 clk = ~clk;

    shadow_stack_unit i_shadow_stack_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
        .op_code(op_code), .rd_idx(rd_idx), .rs1_idx(rs1_idx),
        .rs1_val(rs1_val), .rs2_val(rs2_val), .ss_enable(ss_enable),
        .mop_support(mop_support), .wide_mode(wide_mode),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_kind(mem_req_kind), .mem_req_wide(mem_req_wide),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_err(mem_rsp_err),
        .mem_rsp_data(mem_rsp_data), .wb_valid(wb_valid), .wb_we(wb_we),
        .wb_rd(wb_rd), .wb_data(wb_data), .fault_illegal(fault_illegal),
        .fault_misalign(fault_misalign), .fault_access(fault_access)
    );

    // ---------------- memory model ----------------
    logic [63:0] mem [0:63];
    logic        err_en = 1'b0;
    logic        stall_en = 1'b0;
    int          stall_cnt = 0;
    int          req_count = 0;
    logic [63:0] m_old;
    logic [63:0] m_new;
    logic [5:0]  m_idx;

    assign mem_req_ready = !(stall_en && stall_cnt < 3);

    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) mem[i] <= '0;
            stall_cnt <= 0;
        end else if (mem_req_valid && !mem_req_ready) begin
            stall_cnt <= stall_cnt + 1;
        end else if (mem_req_valid) begin
            stall_cnt <= 0;
            req_count <= req_count + 1;
            m_idx = mem_req_addr[8:3];
            m_old = mem[m_idx];
            m_new = m_old;
            if (mem_req_wide) begin
                mem_rsp_data <= m_old;
                m_new = mem_req_wdata;
            end else if (mem_req_addr[2]) begin
                mem_rsp_data <= {32'hDEADBEEF, m_old[63:32]};
                m_new = {mem_req_wdata[31:0], m_old[31:0]};
            end else begin
                mem_rsp_data <= {32'hDEADBEEF, m_old[31:0]};
                m_new = {m_old[63:32], mem_req_wdata[31:0]};
            end
            if (mem_req_kind != 2'd0 && !err_en) mem[m_idx] <= m_new;
            mem_rsp_err   <= err_en;
            mem_rsp_valid <= 1'b1;
        end
    end

    // ---------------- helpers ----------------
    logic             r_we, r_fi, r_fm, r_fa, r_busy_ready, r_pulse_ok;
    logic [IDX_W-1:0] r_rd;
    logic [XLEN-1:0]  r_data;
    int               r_lat;
    int               r_reqs;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_op(input logic [2:0] opc, input logic [4:0] rd, input logic [4:0] rs1,
                          input logic [63:0] v1, input logic [63:0] v2);
        int start_reqs;
        start_reqs = req_count;
        @(negedge clk);
        op_code = opc; rd_idx = rd; rs1_idx = rs1; rs1_val = v1; rs2_val = v2;
        op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
        r_lat = 1;
        r_busy_ready = 1'b0;
        while (!wb_valid && r_lat < 50) begin
            if (op_ready) r_busy_ready = 1'b1;
            @(negedge clk);
            r_lat++;
        end
        r_we = wb_we; r_rd = wb_rd; r_data = wb_data;
        r_fi = fault_illegal; r_fm = fault_misalign; r_fa = fault_access;
        @(negedge clk);
        r_pulse_ok = !wb_valid;
        r_reqs = req_count - start_reqs;
    endtask

    task automatic expect_ptr(input logic [63:0] exp, input string tag);
        logic sv_en;
        sv_en = ss_enable;
        ss_enable = 1'b1;
        run_op(OP_RDPTR, 5'd6, 5'd0, '0, '0);
        ss_enable = sv_en;
        check(r_we && r_rd == 5'd6 && r_data == exp, tag, r_data, exp);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset;
        check(op_ready && !wb_valid && !mem_req_valid, "R12 idle after reset",
              {61'd0, op_ready, wb_valid, mem_req_valid}, 64'd4);
        run_op(OP_RDPTR, 5'd10, 5'd0, '0, '0);
        check(r_we && r_rd == 5'd10 && r_data == 64'h100, "R12 R7 pointer reset value", r_data, 64'h100);
        check(r_lat == 1 && r_pulse_ok, "R11 one-cycle latency and pulse", r_lat, 1);
    endtask

    task automatic t_save_restore_wide;
        wide_mode = 1'b1;
        run_op(OP_SAVE, 5'd0, 5'd1, 64'h1122334455667788, '0);
        check(!r_we && !r_fi && !r_fm && !r_fa && r_reqs == 1, "R1 wide save completes", r_reqs, 1);
        expect_ptr(64'hF8, "R1 pointer lowered by 8");
        run_op(OP_RESTORE, 5'd5, 5'd0, '0, '0);
        check(r_we && r_rd == 5'd5 && r_data == 64'h1122334455667788, "R2 wide restore data",
              r_data, 64'h1122334455667788);
        expect_ptr(64'h100, "R2 pointer raised by 8");
    endtask

    task automatic t_save_restore_narrow;
        wide_mode = 1'b0;
        run_op(OP_SAVE, 5'd0, 5'd5, 64'hFFFF000087654321, '0);
        expect_ptr(64'hFC, "R1 pointer lowered by 4");
        run_op(OP_RESTORE, 5'd1, 5'd0, '0, '0);
        check(r_we && r_data == 64'h0000000087654321, "R2 narrow restore zero-extends",
              r_data, 64'h0000000087654321);
        expect_ptr(64'h100, "R2 pointer raised by 4");
        wide_mode = 1'b1;
    endtask

    task automatic t_lifo;
        run_op(OP_SAVE, 5'd0, 5'd1, 64'hAAAA0001, '0);
        run_op(OP_SAVE, 5'd0, 5'd5, 64'hBBBB0002, '0);
        run_op(OP_RESTORE, 5'd1, 5'd0, '0, '0);
        check(r_data == 64'hBBBB0002, "R2 last saved restored first", r_data, 64'hBBBB0002);
        run_op(OP_RESTORE, 5'd5, 5'd0, '0, '0);
        check(r_data == 64'hAAAA0001, "R2 first saved restored last", r_data, 64'hAAAA0001);
        expect_ptr(64'h100, "R2 pointer back after pairs");
    endtask

    task automatic t_bad_reg;
        run_op(OP_SAVE, 5'd9, 5'd2, 64'h55, '0);
        check(r_we && r_rd == 5'd9 && r_data == 0 && r_reqs == 0, "R3 save from x2 falls back", r_data, 0);
        run_op(OP_RESTORE, 5'd3, 5'd0, '0, '0);
        check(r_we && r_rd == 5'd3 && r_data == 0 && r_reqs == 0, "R3 restore into x3 falls back", r_reqs, 0);
        expect_ptr(64'h100, "R3 pointer untouched");
    endtask

    task automatic t_disabled;
        ss_enable = 1'b0;
        run_op(OP_SAVE, 5'd8, 5'd1, 64'h77, '0);
        check(r_we && r_rd == 5'd8 && r_data == 0 && r_reqs == 0, "R4 disabled save writes zero", r_data, 0);
        run_op(OP_RDPTR, 5'd8, 5'd0, '0, '0);
        check(r_we && r_data == 0, "R4 disabled pointer read yields zero", r_data, 0);
        run_op(OP_XCHG, 5'd7, 5'd0, 64'hF8, 64'h1);
        check(r_we && r_data == 0 && r_reqs == 0, "R4 disabled exchange no access", r_reqs, 0);
        ss_enable = 1'b1;
        expect_ptr(64'h100, "R4 pointer untouched");
    endtask

    task automatic t_no_mop;
        mop_support = 1'b0;
        ss_enable = 1'b0;
        run_op(OP_SAVE, 5'd8, 5'd1, 64'h77, '0);
        check(r_fi && !r_we, "R5 disabled without fallback faults", r_fi, 1);
        ss_enable = 1'b1;
        run_op(OP_RESTORE, 5'd4, 5'd0, '0, '0);
        check(r_fi && !r_we && r_reqs == 0, "R5 bad register without fallback faults", r_fi, 1);
        mop_support = 1'b1;
    endtask

    task automatic t_check;
        run_op(OP_CHECK, 5'd0, 5'd1, 64'h4000, 64'h4000);
        check(!r_fi && !r_we, "R6 equal links pass", r_fi, 0);
        run_op(OP_CHECK, 5'd0, 5'd1, 64'h4000, 64'h4004);
        check(r_fi && !r_we, "R6 different links fault", r_fi, 1);
    endtask

    task automatic t_xchg;
        run_op(OP_SAVE, 5'd0, 5'd1, 64'hCAFEF00D12345678, '0);
        run_op(OP_XCHG, 5'd7, 5'd0, 64'hF8, 64'h0000000011110000);
        check(r_we && r_rd == 5'd7 && r_data == 64'hCAFEF00D12345678, "R8 wide exchange old word",
              r_data, 64'hCAFEF00D12345678);
        run_op(OP_RESTORE, 5'd1, 5'd0, '0, '0);
        check(r_data == 64'h0000000011110000, "R8 exchange stored new word", r_data, 64'h11110000);
        wide_mode = 1'b0;
        run_op(OP_SAVE, 5'd0, 5'd1, 64'h90000001, '0);
        run_op(OP_XCHG, 5'd7, 5'd0, 64'hFC, 64'h1234);
        check(r_data == 64'hFFFFFFFF90000001, "R8 narrow exchange sign-extends", r_data, 64'hFFFFFFFF90000001);
        run_op(OP_RESTORE, 5'd1, 5'd0, '0, '0);
        check(r_data == 64'h1234, "R8 narrow exchange stored", r_data, 64'h1234);
        wide_mode = 1'b1;
        run_op(OP_XCHG, 5'd0, 5'd0, 64'hF8, 64'h9);
        check(r_we && r_rd == 0 && r_data == 0 && r_reqs == 0, "R8 rd x0 falls back", r_reqs, 0);
        expect_ptr(64'h100, "R8 pointer after exchanges");
    endtask

    task automatic t_misalign;
        run_op(OP_XCHG, 5'd7, 5'd0, 64'h44, 64'h1);
        check(r_fm && !r_we && r_reqs == 0, "R9 wide exchange at 0x44", r_fm, 1);
        wide_mode = 1'b0;
        run_op(OP_XCHG, 5'd7, 5'd0, 64'h42, 64'h1);
        check(r_fm && !r_we && r_reqs == 0, "R9 narrow exchange at 0x42", r_fm, 1);
        run_op(OP_SAVE, 5'd0, 5'd1, 64'h3, '0);
        wide_mode = 1'b1;
        run_op(OP_SAVE, 5'd0, 5'd1, 64'h4, '0);
        check(r_fm && r_reqs == 0, "R9 wide save from pointer 0xFC", r_fm, 1);
        expect_ptr(64'hFC, "R9 pointer kept on misalign");
        wide_mode = 1'b0;
        run_op(OP_RESTORE, 5'd1, 5'd0, '0, '0);
        check(r_data == 64'h3, "R9 narrow data intact", r_data, 64'h3);
        wide_mode = 1'b1;
    endtask

    task automatic t_error;
        err_en = 1'b1;
        run_op(OP_SAVE, 5'd0, 5'd1, 64'h66, '0);
        check(r_fa && !r_we && r_reqs == 1, "R10 save error response", r_fa, 1);
        run_op(OP_RESTORE, 5'd5, 5'd0, '0, '0);
        check(r_fa && !r_we, "R10 restore error response", r_fa, 1);
        err_en = 1'b0;
        expect_ptr(64'h100, "R10 pointer kept on error");
    endtask

    task automatic t_handshake;
        stall_en = 1'b1;
        run_op(OP_SAVE, 5'd0, 5'd1, 64'h5151, '0);
        check(!r_busy_ready && r_pulse_ok && r_lat >= 6, "R11 stalled request busy and single pulse", r_lat, 6);
        stall_en = 1'b0;
        run_op(OP_RESTORE, 5'd1, 5'd0, '0, '0);
        check(r_data == 64'h5151 && !r_busy_ready, "R11 data after stall", r_data, 64'h5151);
    endtask

    // ---------------- sequence ----------------
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_save_restore_wide();
        t_save_restore_narrow();
        t_lifo();
        t_bad_reg();
        t_disabled();
        t_no_mop();
        t_check();
        t_xchg();
        t_misalign();
        t_error();
        t_handshake();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 100000);
        checks++;
        fails++;
        $display("FAIL R11 watchdog expired actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule